// File: doc/BRIEF.md
# Two-Dimensional Memory Fill Sequencer

This block fills a single-port memory with a pattern that depends on two loop indices. A one-cycle start request launches a fill. From the following cycle on, the block presents exactly one write per clock (enable, address, data) until every (outer, inner) index pair has been visited. It then drops its busy flag and raises done in the same cycle. The outer count, the inner count and the first address are elaboration parameters.

Both indices live in a single concatenated state register. This makes the two-level loop behave as one counter with a conditional wrap at the inner boundary. The inner index advances fastest. The data for each write comes from a small combinational pattern submodule that is fed the current index pair, and it can be swapped for another function without touching the sequencing logic. Done is held until another fill is accepted. A start request that arrives during a fill is dropped.

Top module: `fill_sequencer`

## Requirements
- R1: After synchronous reset, `wr_en_o`, `busy_o` and `done_o` are all 0.
- R2: A `start_i` sampled high while not busy makes the next cycle the first write: `wr_en_o`=1, `wr_addr_o`=`BASE_ADDR`, data for index pair (0,0), `busy_o`=1, `done_o`=0.
- R3: During a fill exactly one write is presented per cycle, with no gaps. The address rises by one each cycle, and a fill writes every address from `BASE_ADDR` to `BASE_ADDR`+`OUTER_N`*`INNER_N`-1 exactly once.
- R4: The inner index runs 0 to `INNER_N`-1. After `INNER_N`-1 it returns to 0 and the outer index rises by one, so write number k carries outer=k/`INNER_N`, inner=k mod `INNER_N`.
- R5: Write data equals ((outer << 8) | inner) XOR 16'h5A3C, truncated to `DATA_W` bits.
- R6: In the cycle after the write for pair (`OUTER_N`-1, `INNER_N`-1), `done_o`=1 and `busy_o`=`wr_en_o`=0. `done_o` stays 1 until a start is accepted.
- R7: A `start_i` sampled while busy, including during the last write, has no effect: the address and data sequence continues unchanged and the fill ends at the same cycle.
- R8: A `start_i` accepted while done clears `done_o` in the next cycle and runs a complete fill again from `BASE_ADDR` and pair (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a fill; honoured only when not busy |
| wr_en_o | output | 1 | Memory write enable, high once per fill cycle |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | DATA_W | Memory write data from the pattern function |
| busy_o | output | 1 | A fill is in progress |
| done_o | output | 1 | Last fill has completed; held until the next accepted start |

## Verification
The bench tracks every write against a running write number. A design that wrapped the inner index one step early or late, or that advanced the outer index at the wrong time, would show up as wrong data at the boundary writes. A design that skipped or repeated a write would show a broken address step or a per-address write count other than one. Start pulses are sprayed at random into running fills, including the final write cycle. A design that honoured them would jump back to the base address or stretch the fill. Fills are rerun after random idle gaps to catch done dropping early, or a restart that keeps stale indices or a stale address.

// File: rtl/fill_pkg.sv
package fill_pkg;

    localparam int unsigned   PAT_SHIFT = 8;
    localparam logic [31:0]   PAT_MASK  = 32'h0000_5A3C;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } fill_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fill_pattern.sv
module fill_pattern import fill_pkg::*; #(
    parameter int OW     = 3,
    parameter int IW     = 3,
    parameter int DATA_W = 16
) (
    input  logic [OW-1:0]     outer_i,
    input  logic [IW-1:0]     inner_i,
    output logic [DATA_W-1:0] data_o
);

    logic [31:0] raw;

    always_comb begin
        raw    = (32'(outer_i) << PAT_SHIFT) | 32'(inner_i);
        data_o = DATA_W'(raw ^ PAT_MASK);
    end

endmodule

// File: rtl/fill_index_walker.sv
module fill_index_walker import fill_pkg::*; #(
    parameter int OUTER_N = 5,
    parameter int INNER_N = 7
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clear_i,
    input  logic                              step_i,
    output logic [idx_width(OUTER_N)-1:0]     outer_o,
    output logic [idx_width(INNER_N)-1:0]     inner_o,
    output logic                              last_o
);

    localparam int OW = idx_width(OUTER_N);
    localparam int IW = idx_width(INNER_N);
    localparam logic [OW-1:0] OUTER_MAX = OW'(OUTER_N - 1);
    localparam logic [IW-1:0] INNER_MAX = IW'(INNER_N - 1);

    logic [OW+IW-1:0] pair_q;
    logic [OW+IW-1:0] pair_d;
    logic             inner_end;

    assign outer_o   = pair_q[IW +: OW];
    assign inner_o   = pair_q[IW-1:0];
    assign inner_end = (inner_o == INNER_MAX);
    assign last_o    = inner_end && (outer_o == OUTER_MAX);

    always_comb begin
        pair_d = pair_q;
        if (clear_i) begin
            pair_d = '0;
        end else if (step_i && !last_o) begin
            if (inner_end) begin
                pair_d = {OW'(outer_o + 1'b1), IW'(0)};
            end else begin
                pair_d = {outer_o, IW'(inner_o + 1'b1)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    AST_INNER_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clear_i && inner_end && !last_o) |=>
            (inner_o == '0 && outer_o == OW'($past(outer_o) + 1'b1))); // R4

    AST_INNER_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clear_i && !inner_end) |=>
            (inner_o == IW'($past(inner_o) + 1'b1) && $stable(outer_o))); // R4

endmodule

// File: rtl/fill_addr_gen.sv
module fill_addr_gen #(
    parameter int          ADDR_W    = 12,
    parameter int unsigned BASE_ADDR = 'h040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= BASE;
        end else if (clear_i) begin
            addr_o <= BASE;
        end else if (step_i) begin
            addr_o <= addr_o + 1'b1;
        end
    end

endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer import fill_pkg::*; #(
    parameter int          OUTER_N   = 5,
    parameter int          INNER_N   = 7,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 16,
    parameter int unsigned BASE_ADDR = 'h040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int OW = idx_width(OUTER_N);
    localparam int IW = idx_width(INNER_N);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    fill_state_e   state_q;
    fill_state_e   state_d;
    logic          accept;
    logic          step;
    logic          last;
    logic [OW-1:0] outer;
    logic [IW-1:0] inner;

    assign accept = start_i && (state_q != ST_FILL);
    assign step   = (state_q == ST_FILL);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_DONE: if (start_i) state_d = ST_FILL;
            ST_FILL:          if (last)    state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    fill_index_walker #(
        .OUTER_N (OUTER_N),
        .INNER_N (INNER_N)
    ) u_walker (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .step_i  (step),
        .outer_o (outer),
        .inner_o (inner),
        .last_o  (last)
    );

    fill_addr_gen #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .step_i  (step),
        .addr_o  (wr_addr_o)
    );

    fill_pattern #(
        .OW     (OW),
        .IW     (IW),
        .DATA_W (DATA_W)
    ) u_pattern (
        .outer_i (outer),
        .inner_i (inner),
        .data_o  (wr_data_o)
    );

    assign wr_en_o = step;
    assign busy_o  = step;
    assign done_o  = (state_q == ST_DONE);

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en_o) |-> (wr_addr_o == BASE)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1))); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en_o); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o); // R6

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !$rose(busy_o)) |=> (busy_o || done_o)); // R7

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (wr_en_o && !done_o && wr_addr_o == BASE)); // R8

endmodule

// File: tb/fill_sequencer_bench.sv
module fill_sequencer_bench;

    localparam int          OUTER_N   = 5;
    localparam int          INNER_N   = 7;
    localparam int          ADDR_W    = 12;
    localparam int          DATA_W    = 16;
    localparam int unsigned BASE_ADDR = 'h040;
    localparam int          TOTAL     = OUTER_N * INNER_N;
    localparam int          MEM_SIZE  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              wr_en_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [DATA_W-1:0] wr_data_o;
    logic              busy_o;
    logic              done_o;

    int total = 0;
    int bad   = 0;
    int wcount [MEM_SIZE];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fill_sequencer #(
        .OUTER_N   (OUTER_N),
        .INNER_N   (INNER_N),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_fill_sequencer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    function automatic logic [DATA_W-1:0] exp_data(input int k);
        int o = k / INNER_N;
        int i = k % INNER_N;
        return DATA_W'(((o << 8) | i) ^ 32'h5A3C);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && wr_en_o) wcount[wr_addr_o]++;
    end

    task automatic clear_counts();
        for (int a = 0; a < MEM_SIZE; a++) wcount[a] = 0;
    endtask

    task automatic run_fill(input bit spray, input bit from_done);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 first write enable", wr_en_o, 1);
        check("R2 first address", wr_addr_o, BASE_ADDR);
        check("R2 busy", busy_o, 1);
        if (from_done) check("R8 done cleared", done_o, 0);
        else           check("R2 done low", done_o, 0);
        for (int k = 0; k < TOTAL; k++) begin
            start_i = 1'b0;
            check("R3 write enable", wr_en_o, 1);
            check("R3 address", wr_addr_o, BASE_ADDR + k);
            if ((k % INNER_N) == 0 || (k % INNER_N) == INNER_N - 1)
                check("R4 boundary data", wr_data_o, exp_data(k));
            else
                check("R5 data", wr_data_o, exp_data(k));
            if (spray && ($urandom % 3 == 0 || k == TOTAL - 1)) start_i = 1'b1;
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R6 done set", done_o, 1);
        check("R6 busy clear", busy_o, 0);
        check("R7 no write after end", wr_en_o, 0);
        for (int a = 0; a < MEM_SIZE; a++) begin
            if (a >= BASE_ADDR && a < BASE_ADDR + TOTAL) begin
                if (wcount[a] != 1) check("R3 written once", wcount[a], 1);
            end else if (wcount[a] != 0) begin
                check("R3 untouched", wcount[a], 0);
            end
        end
        total++;
        clear_counts();
    endtask

    initial begin
        void'($urandom(32'd1234));
        clear_counts();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 wr_en reset", wr_en_o, 0);
        check("R1 busy reset", busy_o, 0);
        check("R1 done reset", done_o, 0);

        run_fill(1'b0, 1'b0);
        for (int r = 0; r < 3; r++) begin
            int gap = 1 + ($urandom % 20);
            repeat (gap) @(negedge clk);
            check("R6 done held", done_o, 1);
            check("R6 idle no write", wr_en_o, 0);
            run_fill(1'b1, 1'b1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule